// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block is a memory-mapped mailbox shared by an application processor and a co-processor. Messages travel in two fixed directions, each through its own FIFO. Direction 0 carries traffic from the application side to the I/O side. Direction 1 carries traffic the other way. A message is a 64-bit head word plus a 32-bit payload word. Both processors reach the same register set through one simple register bus, which has 8-bit byte offsets and 64-bit data.

A sender writes the head word first and then the payload word. The write of the payload word enqueues the message. A receiver reads the head word, which does not consume the message. It then reads the payload word, which dequeues the message. The payload read also reports the FIFO occupancy, the free slots and both ring pointers, all sampled before the dequeue.

Four interrupt sources cover "FIFO empty" and "FIFO not empty" for each direction. Each source is sticky, and software clears it by writing a 1 to its acknowledge bit. Each direction has one level interrupt line: its two pending sources, masked by their enable bits, ORed together.

Top module: `ipc_mailbox`

## Requirements
- R1: Messages leave each FIFO in the order they were written. A read of the head receive word (direction base + 0x20) returns the 64-bit head word. The payload occupies bits 31:0 of the second word, and bits 63:32 of a written payload word are discarded.
- R2: A write to the head send word (direction base + 0x10) only stages the word. The message is enqueued when the payload send word (direction base + 0x18) is written, using the most recently staged head word.
- R3: The direction bases are 0x50 (application to I/O) and 0x80 (I/O to application). A read of the base offset returns FIFO full in bit 16 and FIFO empty in bit 17, with the unused bits zero.
- R4: A payload write to a FIFO that already holds 16 messages is dropped and leaves the contents unchanged. It also sets a sticky overflow bit 18 in that direction's status word, which stays set until reset.
- R5: A read of either receive word while the FIFO is empty returns zero and leaves the pointers unchanged.
- R6: There are four interrupt sources. Bit 0 is direction-0 empty, bit 1 is direction-0 not empty, bit 2 is direction-1 empty and bit 3 is direction-1 not empty. A source latches once its condition has been true, and it stays pending until it is acknowledged. A read of offset 0x4C returns the pending bits.
- R7: Writing 1 to a bit of offset 0x4C clears that pending bit at the next clock edge. If the condition still holds, the bit is set again one clock edge later. Bits written as 0 are unaffected.
- R8: The enable register is at offset 0x48, uses bits 3:0 and reads back. irq_fwd is high exactly when pending bit 0 or 1 is set together with its enable. irq_rev does the same for bits 2 and 3.
- R9: A read of the payload receive word (direction base + 0x28) returns and dequeues the head message. It reports, all sampled before the dequeue: the occupancy in bits 56:52, the free slots modulo 16 in bits 51:48, the read pointer in bits 47:44 and the write pointer in bits 43:40. The payload is in bits 31:0, and every other bit is zero.
- R10: The two directions are independent. Traffic on one direction never changes the contents, flags or pointers of the other.
- R11: After reset, both FIFOs are empty with pointers at zero, the overflow bits and enables are zero, the read data is zero and both interrupt lines are low. On the first clock after reset, both "empty" sources become pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered, valid the cycle after the read |
| irq_fwd | output | 1 | Interrupt line for direction 0 sources |
| irq_rev | output | 1 | Interrupt line for direction 1 sources |

## Verification
The results arrive at different times after the clock edge that accepts an access.
- Read data, FIFO flags, the overflow bit and the interrupt lines (after an enable write) are all valid after that same edge.
- A pending bit follows a FIFO change one edge later.
- After an acknowledge, the pending bit is low after the acknowledging edge and high again after the next edge.

The bench drives every access on a falling edge and samples on the falling edge after the accepting edge. For the re-assertion check it samples on two consecutive falling edges. A status read always leaves at least one idle edge after the last FIFO change, so the pending bits have settled before they are read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 64;
  localparam int PAY_W  = 32;
  localparam int MSG_W  = BUS_DW + PAY_W;
  localparam int NDIR   = 2;
  localparam int NSRC   = 2 * NDIR;

  localparam logic [BUS_AW-1:0] OFS_IRQ_EN  = 8'h48;
  localparam logic [BUS_AW-1:0] OFS_IRQ_ACK = 8'h4C;
  localparam logic [BUS_AW-1:0] REL_STAT = 8'h00;
  localparam logic [BUS_AW-1:0] REL_SND0 = 8'h10;
  localparam logic [BUS_AW-1:0] REL_SND1 = 8'h18;
  localparam logic [BUS_AW-1:0] REL_RCV0 = 8'h20;
  localparam logic [BUS_AW-1:0] REL_RCV1 = 8'h28;

  function automatic logic [BUS_AW-1:0] dir_base(input int d);
    return (d == 0) ? 8'h50 : 8'h80;
  endfunction

  // status word: full in 16, empty in 17, sticky overflow in 18
  function automatic logic [BUS_DW-1:0] stat_word(input logic full, input logic empty,
                                                  input logic ovf);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[16] = full;
    w[17] = empty;
    w[18] = ovf;
    return w;
  endfunction

  // second receive word with occupancy, free slots and ring pointers
  function automatic logic [BUS_DW-1:0] rx_tail_word(input logic [4:0] occ,
                                                     input logic [3:0] free,
                                                     input logic [3:0] rp,
                                                     input logic [3:0] wp,
                                                     input logic [PAY_W-1:0] pay);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[56:52] = occ;
    w[51:48] = free;
    w[47:44] = rp;
    w[43:40] = wp;
    w[PAY_W-1:0] = pay;
    return w;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [PTR_W:0]   occ,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam logic [PTR_W:0]   DEPTH_V = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W:0]   occ_q;
  logic [PTR_W-1:0] rp_q, wp_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ_q == DEPTH_V);
  assign empty   = (occ_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp_q];
  assign occ     = occ_q;
  assign rd_ptr  = rp_q;
  assign wr_ptr  = wp_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      rp_q  <= '0;
      wp_q  <= '0;
    end else begin
      if (push_ok) wp_q <= step(wp_q);
      if (pop_ok)  rp_q <= step(rp_q);
      occ_q <= occ_q + (PTR_W+1)'(push_ok) - (PTR_W+1)'(pop_ok);
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_din,
  input  logic [NSRC-1:0] ack,
  input  logic [NSRC-1:0] cond,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q <= en_din;
      pend_q <= (pend_q | cond) & ~ack;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_fwd,
  output logic              irq_rev
);
  localparam logic [PTR_W:0] DEPTH_V = (PTR_W+1)'(DEPTH);

  logic wr_cyc, rd_cyc;
  assign wr_cyc = bus_en && bus_we;
  assign rd_cyc = bus_en && !bus_we;

  logic [NDIR-1:0] full_w, empty_w, ovf_w, push_req, pop_req, push_ok, pop_ok;
  logic [NDIR-1:0][MSG_W-1:0] head_w;
  logic [NDIR-1:0][PTR_W:0]   occ_w;
  logic [NDIR-1:0][PTR_W-1:0] rdp_w, wrp_w;
  logic [NSRC-1:0] cond_w, ack_w, en_q, pend_q;
  logic [NDIR-1:0] irq_w;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [BUS_DW-1:0] stage_q;
    logic              ovf_q;
    logic              stage_we;

    assign stage_we    = wr_cyc && (bus_addr == dir_base(d) + REL_SND0);
    assign push_req[d] = wr_cyc && (bus_addr == dir_base(d) + REL_SND1);
    assign pop_req[d]  = rd_cyc && (bus_addr == dir_base(d) + REL_RCV1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
        ovf_q   <= 1'b0;
      end else begin
        if (stage_we) stage_q <= bus_wdata;
        if (push_req[d] && full_w[d]) ovf_q <= 1'b1;
      end
    end
    assign ovf_w[d] = ovf_q;

    mbox_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_req[d]),
      .pop     (pop_req[d]),
      .din     ({stage_q, bus_wdata[PAY_W-1:0]}),
      .head    (head_w[d]),
      .full    (full_w[d]),
      .empty   (empty_w[d]),
      .occ     (occ_w[d]),
      .rd_ptr  (rdp_w[d]),
      .wr_ptr  (wrp_w[d]),
      .push_ok (push_ok[d]),
      .pop_ok  (pop_ok[d])
    );

    assign cond_w[2*d]   = empty_w[d];
    assign cond_w[2*d+1] = !empty_w[d];
    assign irq_w[d] = |(pend_q[2*d+1:2*d] & en_q[2*d+1:2*d]);
  end

  assign ack_w = (wr_cyc && bus_addr == OFS_IRQ_ACK) ? bus_wdata[NSRC-1:0] : '0;

  mbox_irq #(.NSRC(NSRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (wr_cyc && bus_addr == OFS_IRQ_EN),
    .en_din (bus_wdata[NSRC-1:0]),
    .ack    (ack_w),
    .cond   (cond_w),
    .en_q   (en_q),
    .pend_q (pend_q)
  );

  assign irq_fwd = irq_w[0];
  assign irq_rev = irq_w[1];

  logic [BUS_DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (bus_addr == OFS_IRQ_EN)  rd_next = BUS_DW'(en_q);
    if (bus_addr == OFS_IRQ_ACK) rd_next = BUS_DW'(pend_q);
    for (int d = 0; d < NDIR; d++) begin
      if (bus_addr == dir_base(d) + REL_STAT)
        rd_next = stat_word(full_w[d], empty_w[d], ovf_w[d]);
      if (bus_addr == dir_base(d) + REL_RCV0 && !empty_w[d])
        rd_next = head_w[d][MSG_W-1:PAY_W];
      if (bus_addr == dir_base(d) + REL_RCV1 && !empty_w[d])
        rd_next = rx_tail_word(5'(occ_w[d]), 4'(DEPTH_V - occ_w[d]), 4'(rdp_w[d]),
                               4'(wrp_w[d]), head_w[d][PAY_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_cyc) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int NDIR = 2,
  parameter int NSRC = 4,
  parameter int DW = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDIR-1:0] full_w,
  input logic [NDIR-1:0] empty_w,
  input logic [NDIR-1:0] ovf_w,
  input logic [NDIR-1:0] push_req,
  input logic [NDIR-1:0] push_ok,
  input logic [NDIR-1:0] pop_req,
  input logic [NDIR-1:0] pop_ok,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] ack_w,
  input logic [NSRC-1:0] cond_w,
  input logic            irq_fwd,
  input logic            irq_rev,
  input logic [DW-1:0]   bus_rdata
);
  for (genvar d = 0; d < NDIR; d++) begin : g_d
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_w[d] && empty_w[d])); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full_w[d] |-> !push_ok[d]); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req[d] && full_w[d]) |=> ovf_w[d]); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_w[d] |=> ovf_w[d]); // R4
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      empty_w[d] |-> !pop_ok[d]); // R5
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req[d] && empty_w[d]) |=> (bus_rdata == '0)); // R5
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_s
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[s] && !ack_w[s]) |=> pend_q[s]); // R6
    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_w[s] && !ack_w[s]) |=> pend_q[s]); // R6
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w[s] |=> !pend_q[s]); // R7
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_fwd && !irq_rev)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (!irq_fwd && !irq_rev)); // R8
endmodule

bind ipc_mailbox mbox_checker #(.NDIR(2), .NSRC(4), .DW(64)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .full_w    (full_w),
  .empty_w   (empty_w),
  .ovf_w     (ovf_w),
  .push_req  (push_req),
  .push_ok   (push_ok),
  .pop_req   (pop_req),
  .pop_ok    (pop_ok),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .ack_w     (ack_w),
  .cond_w    (cond_w),
  .irq_fwd   (irq_fwd),
  .irq_rev   (irq_rev),
  .bus_rdata (bus_rdata)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        irq_fwd, irq_rev;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_fwd(irq_fwd), .irq_rev(irq_rev)
  );

  // reference ring, restated from the requirements
  logic [63:0] m_head [2][16];
  logic [31:0] m_pay  [2][16];
  int m_rp[2], m_wp[2], m_occ[2];
  bit m_ovf[2];

  function automatic logic [7:0] base_of(input int d);
    return (d == 0) ? 8'h50 : 8'h80;
  endfunction

  function automatic logic [63:0] exp_stat(input int d);
    logic [63:0] w;
    w = 64'd0;
    if (m_occ[d] == 16) w = w | (64'd1 << 16);
    if (m_occ[d] == 0)  w = w | (64'd1 << 17);
    if (m_ovf[d])       w = w | (64'd1 << 18);
    return w;
  endfunction

  function automatic logic [63:0] exp_tail(input int d);
    if (m_occ[d] == 0) return 64'd0;
    return (64'(m_occ[d]) << 52) | (64'((16 - m_occ[d]) % 16) << 48) |
           (64'(m_rp[d]) << 44) | (64'(m_wp[d]) << 40) | 64'(m_pay[d][m_rp[d]]);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [63:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [63:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic send(input int d, input logic [63:0] h, input logic [31:0] p);
    bwr(base_of(d) + 8'h10, h);
    bwr(base_of(d) + 8'h18, {$urandom(), p});
    if (m_occ[d] == 16) m_ovf[d] = 1'b1;
    else begin
      m_head[d][m_wp[d]] = h;
      m_pay[d][m_wp[d]] = p;
      m_wp[d] = (m_wp[d] + 1) % 16;
      m_occ[d]++;
    end
  endtask

  task automatic recv(input int d, input string req);
    logic [63:0] v;
    brd(base_of(d) + 8'h20, v);
    check({req, " head word"}, v, (m_occ[d] == 0) ? 64'd0 : m_head[d][m_rp[d]]);
    brd(base_of(d) + 8'h28, v);
    check({req, " tail word"}, v, exp_tail(d));
    if (m_occ[d] != 0) begin
      m_rp[d] = (m_rp[d] + 1) % 16;
      m_occ[d]--;
    end
  endtask

  task automatic stat(input int d, input string req);
    logic [63:0] v;
    brd(base_of(d), v);
    check(req, v, exp_stat(d));
  endtask

  initial begin
    logic [63:0] v;
    void'($urandom(32'd2024));
    for (int d = 0; d < 2; d++) begin
      m_rp[d] = 0; m_wp[d] = 0; m_occ[d] = 0; m_ovf[d] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 rdata after reset", bus_rdata, 64'd0);
    check("R11 irq lines after reset", {62'd0, irq_fwd, irq_rev}, 64'd0);
    @(negedge clk);
    brd(8'h48, v); check("R11 enables reset", v, 64'd0);
    brd(8'h4C, v); check("R11 R6 empty sources pending", v, 64'h5);
    stat(0, "R3 R11 dir0 empty"); stat(1, "R3 R11 dir1 empty");

    // R2: staging alone enqueues nothing
    bwr(8'h60, 64'hDEAD_BEEF_0000_0001);
    stat(0, "R2 head write alone");
    // R5: empty read gives zero and moves nothing
    recv(0, "R5 empty read");

    // interrupt sequence
    send(0, 64'h1111_2222_3333_4444, 32'hA5A5_0001);
    @(negedge clk);
    brd(8'h4C, v); check("R6 sticky empty plus not-empty", v, 64'h7);
    bwr(8'h4C, 64'h1);
    @(negedge clk);
    brd(8'h4C, v); check("R7 ack clears false source", v, 64'h6);
    bwr(8'h48, 64'h2);
    check("R8 irq_fwd with bit1 enabled", 64'(irq_fwd), 64'd1);
    check("R8 irq_rev masked", 64'(irq_rev), 64'd0);
    bwr(8'h4C, 64'h2);
    check("R7 drop after ack", 64'(irq_fwd), 64'd0);
    @(negedge clk);
    check("R7 reassert next cycle", 64'(irq_fwd), 64'd1);
    bwr(8'h48, 64'h4);
    check("R8 irq_rev from dir1 empty", 64'(irq_rev), 64'd1);
    check("R8 irq_fwd disabled", 64'(irq_fwd), 64'd0);
    recv(0, "R1 single message");
    @(negedge clk);
    brd(8'h4C, v); check("R6 empty source relatched", v[0], 1'b1);
    bwr(8'h4C, 64'hF);
    @(negedge clk);
    brd(8'h4C, v); check("R7 ack all then relatch", v, 64'h5);
    bwr(8'h48, 64'h0);

    // R4: fill direction 1 past full
    for (int i = 0; i < 17; i++) send(1, 64'(i) * 64'h0101_0101_0101_0101, 32'hC000_0000 + i);
    stat(1, "R4 full and overflow");
    stat(0, "R10 dir0 untouched");
    for (int i = 0; i < 16; i++) recv(1, "R1 R9 drain order");
    stat(1, "R4 overflow sticky after drain");

    // random interleaving
    for (int n = 0; n < 800; n++) begin
      int d, op;
      d = int'($urandom_range(0, 1));
      op = int'($urandom_range(0, 9));
      if (op < 5) send(d, {$urandom(), $urandom()}, $urandom());
      else if (op < 9) recv(d, "R1 R9 R10 random");
      else stat(d, "R3 R4 random status");
    end
    for (int d = 0; d < 2; d++) while (m_occ[d] > 0) recv(d, "R1 R9 final drain");
    stat(0, "R3 final"); stat(1, "R3 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule